// File: doc/BRIEF.md
# Clock Request and Crystal Fail-Safe Controller

This block is the decision logic of a small microcontroller clock system. Every reference-clock cycle it works out which of four clock gates are open: the main clock (MCLK), the subsystem clock (SMCLK), the auxiliary clock (ACLK) and the module oscillator (MODOSC). It also works out which oscillator each selectable clock really uses. It produces enables and select codes only. The clock multiplexers, oscillators and frequency tuning sit elsewhere.

Gating starts from a low-power-mode code. Any clock whose request-enable bit is set stays open while a peripheral requests it, whatever the mode. A crystal fault is synchronized and then handled by a three-state machine. `XS_RUN` means the crystal is healthy. On a fault, the transition RUN→FAIL_LF is taken when the crystal runs in low-frequency mode, and RUN→FAIL_HF when it runs in high-frequency mode. Each fail state forces crystal-sourced clocks onto a fallback source. The fail states leave only through FAIL_LF→RUN or FAIL_HF→RUN, which need a software clear while the synchronized fault is low. A clear that arrives while the fault is still present is a self-loop. The block also registers a memory wait-state count from the MCLK frequency setting.

Top module: `clkreq_fallback_ctrl`

## Requirements
- R1: When bit i of `req_en` is set and any bit of the matching request vector is high, gate i is 1 after the next rising edge, in every low-power mode. Gate bit order: 0 MCLK, 1 SMCLK, 2 ACLK, 3 MODOSC.
- R2: When bit i of `req_en` is clear, requests on clock i have no effect and gate i follows only the mode table in R3.
- R3: The mode table, written as gate bits [3:0], is registered on the next edge: code 0 gives 1111, code 1 gives 1110, code 2 gives 0110, code 3 gives 0100, and codes 4 to 7 give 0000.
- R4: In mode 3, SMCLK (gate bit 1) is 0 unless its request-enable bit is set and it has an active request.
- R5: In the low-frequency fail state, a crystal select (source code 1) on MCLK or ACLK is reported as the reference oscillator (code 2). Source codes: 0 divided DCO, 1 crystal, 2 reference oscillator, 3 very-low-power oscillator.
- R6: In the high-frequency fail state, a crystal select on MCLK is reported as the divided DCO (code 0). A crystal select on ACLK is reported as the reference oscillator, because the ACLK mux has no DCO input.
- R7: The fault flag rises on the third rising edge after `xt_fault_raw` goes high. It then stays set until a clear is pulsed while the synchronized fault is low. The frequency mode is captured when the fault is entered, and the fallback stays in force while the flag is set.
- R8: The fault interrupt enable changes only on a write. A fault never clears it. `fault_irq` is the flag ANDed with the enable.
- R9: `mem_wait` is 1 one edge after `mclk_freq_mhz` exceeds 8, and 0 at 8 or below.
- R10: ACLK reports only source codes 1, 2 or 3; a requested code 0 is reported as 2. A select that does not name the crystal passes through unchanged, even during a fault.
- R11: During reset all four gates are 1, the flag, enable, interrupt and wait state are 0, MCLK reports code 0 and ACLK reports code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpm_code | input | 3 | Low-power-mode code |
| req_mclk | input | NUM_REQ | Peripheral requests for MCLK |
| req_smclk | input | NUM_REQ | Peripheral requests for SMCLK |
| req_aclk | input | NUM_REQ | Peripheral requests for ACLK |
| req_modosc | input | NUM_REQ | Peripheral requests for the module oscillator |
| req_en | input | 4 | Per-clock request-enable bits |
| xt_fault_raw | input | 1 | Asynchronous crystal fault indication |
| xt_hf_mode | input | 1 | Crystal runs in high-frequency mode |
| mclk_src_sel | input | 2 | Software MCLK source |
| aclk_src_sel | input | 2 | Software ACLK source |
| mclk_freq_mhz | input | FREQ_W | MCLK frequency setting in MHz |
| fault_clr | input | 1 | Software clear of the fault flag |
| fault_ie_wr | input | 1 | Write strobe for the fault interrupt enable |
| fault_ie_wdata | input | 1 | Value written to the interrupt enable |
| gate_en | output | 4 | Registered gate enables |
| mclk_src_eff | output | 2 | Source actually driving MCLK (and SMCLK) |
| aclk_src_eff | output | 2 | Source actually driving ACLK |
| fault_flag | output | 1 | Sticky crystal fault flag |
| fault_ie | output | 1 | Fault interrupt enable |
| fault_irq | output | 1 | Fault interrupt |
| mem_wait | output | 1 | Memory wait states |

## Verification
The bench drives every low-power code against every request-enable and request pattern. A design that ORed requests in without checking the enable, or that mistook the mode-3 row, would open the wrong gate. Both fault kinds are raised. The bench checks that the flag is still low two edges after the fault and set on the third, so a missing or extra synchronizer stage shows up. It flips the frequency mode in the middle of a fault, which catches a fallback that reads the live mode input instead of the captured one. It pulses a clear while the fault is still present and checks the interrupt enable after a fault, which catches an early release and an enable that a fault wipes. The wait-state check sits on the 8/9 MHz boundary, where a `>=` comparison would give the wrong answer.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;

    localparam int NCLK      = 4;
    localparam int CI_MCLK   = 0;
    localparam int CI_SMCLK  = 1;
    localparam int CI_ACLK   = 2;
    localparam int CI_MODOSC = 3;

    typedef enum logic [1:0] {
        SRC_DCODIV = 2'd0,
        SRC_XT     = 2'd1,
        SRC_REFO   = 2'd2,
        SRC_VLO    = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        XS_RUN     = 2'd0,
        XS_FAIL_LF = 2'd1,
        XS_FAIL_HF = 2'd2
    } xs_e;

    // Baseline gate pattern for each low-power code, bit order as CI_*.
    function automatic logic [NCLK-1:0] lpm_base(input logic [2:0] code);
        logic [NCLK-1:0] g;
        unique case (code)
            3'd0:    g = 4'b1111;
            3'd1:    g = 4'b1110;
            3'd2:    g = 4'b0110;
            3'd3:    g = 4'b0100;
            default: g = 4'b0000;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/clkreq_sync.sv
module clkreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate
    import clkreq_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     lpm_code,
    input  logic [NCLK-1:0]                req_en,
    input  logic [NCLK-1:0][NUM_REQ-1:0]   req,
    output logic [NCLK-1:0]                gate_q
);
    logic [NCLK-1:0] base;
    logic [NCLK-1:0] any_req;

    assign base = lpm_base(lpm_code);

    for (genvar i = 0; i < NCLK; i++) begin : g_clk
        assign any_req[i] = |req[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gate_q[i] <= 1'b1;
            else        gate_q[i] <= base[i] | (req_en[i] & any_req[i]);
        end

        assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (req_en[i] && (|req[i])) |=> gate_q[i]);

        assert_active_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (lpm_code == 3'd0) |=> gate_q[i]);

        assert_deep_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (lpm_code >= 3'd4 && !(req_en[i] && (|req[i]))) |=> !gate_q[i]);
    end

    assert_lpm3_smclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_code == 3'd3 && !(req_en[CI_SMCLK] && (|req[CI_SMCLK]))) |=> !gate_q[CI_SMCLK]);
endmodule

// File: rtl/clkreq_failsafe.sv
module clkreq_failsafe
    import clkreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_s,
    input  logic       xt_hf_mode,
    input  logic       fault_clr,
    input  logic [1:0] mclk_src_sel,
    input  logic [1:0] aclk_src_sel,
    input  logic       fault_ie_wr,
    input  logic       fault_ie_wdata,
    output logic [1:0] mclk_src_eff,
    output logic [1:0] aclk_src_eff,
    output logic       fault_flag,
    output logic       fault_ie
);
    xs_e  state_q, state_d;
    src_e m_eff_d, a_eff_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_RUN:     if (fault_s) state_d = xt_hf_mode ? XS_FAIL_HF : XS_FAIL_LF;
            XS_FAIL_LF: if (fault_clr && !fault_s) state_d = XS_RUN;
            XS_FAIL_HF: if (fault_clr && !fault_s) state_d = XS_RUN;
            default:    state_d = XS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        m_eff_d = src_e'(mclk_src_sel);
        if (m_eff_d == SRC_XT) begin
            unique case (state_d)
                XS_FAIL_LF: m_eff_d = SRC_REFO;
                XS_FAIL_HF: m_eff_d = SRC_DCODIV;
                default:    m_eff_d = SRC_XT;
            endcase
        end
        a_eff_d = src_e'(aclk_src_sel);
        if (a_eff_d == SRC_DCODIV) a_eff_d = SRC_REFO;
        if (a_eff_d == SRC_XT && state_d != XS_RUN) a_eff_d = SRC_REFO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_src_eff <= SRC_DCODIV;
            aclk_src_eff <= SRC_REFO;
            fault_flag   <= 1'b0;
            fault_ie     <= 1'b0;
        end else begin
            mclk_src_eff <= m_eff_d;
            aclk_src_eff <= a_eff_d;
            fault_flag   <= (state_d != XS_RUN);
            if (fault_ie_wr) fault_ie <= fault_ie_wdata;
        end
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag);

    assert_lf_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_FAIL_LF && !fault_clr && mclk_src_sel == SRC_XT) |=> mclk_src_eff == SRC_REFO);

    assert_hf_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_FAIL_HF && !fault_clr && mclk_src_sel == SRC_XT) |=> mclk_src_eff == SRC_DCODIV);

    assert_ie_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_ie_wr |=> $stable(fault_ie));

    assert_aclk_no_dco_R10: assert property (@(posedge clk) disable iff (!rst_n)
        aclk_src_eff != SRC_DCODIV);
endmodule

// File: rtl/clkreq_fallback_ctrl.sv
module clkreq_fallback_ctrl
    import clkreq_pkg::*;
#(
    parameter int NUM_REQ       = 4,
    parameter int FREQ_W        = 5,
    parameter int WS_THRESH_MHZ = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         lpm_code,
    input  logic [NUM_REQ-1:0] req_mclk,
    input  logic [NUM_REQ-1:0] req_smclk,
    input  logic [NUM_REQ-1:0] req_aclk,
    input  logic [NUM_REQ-1:0] req_modosc,
    input  logic [3:0]         req_en,
    input  logic               xt_fault_raw,
    input  logic               xt_hf_mode,
    input  logic [1:0]         mclk_src_sel,
    input  logic [1:0]         aclk_src_sel,
    input  logic [FREQ_W-1:0]  mclk_freq_mhz,
    input  logic               fault_clr,
    input  logic               fault_ie_wr,
    input  logic               fault_ie_wdata,
    output logic [3:0]         gate_en,
    output logic [1:0]         mclk_src_eff,
    output logic [1:0]         aclk_src_eff,
    output logic               fault_flag,
    output logic               fault_ie,
    output logic               fault_irq,
    output logic               mem_wait
);
    localparam logic [FREQ_W-1:0] WS_LIMIT = FREQ_W'(WS_THRESH_MHZ);

    logic [NCLK-1:0][NUM_REQ-1:0] req_all;
    logic                         fault_s;

    assign req_all[CI_MCLK]   = req_mclk;
    assign req_all[CI_SMCLK]  = req_smclk;
    assign req_all[CI_ACLK]   = req_aclk;
    assign req_all[CI_MODOSC] = req_modosc;

    clkreq_gate #(.NUM_REQ(NUM_REQ)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpm_code (lpm_code),
        .req_en   (req_en),
        .req      (req_all),
        .gate_q   (gate_en)
    );

    clkreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (xt_fault_raw),
        .dout  (fault_s)
    );

    clkreq_failsafe u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault_s        (fault_s),
        .xt_hf_mode     (xt_hf_mode),
        .fault_clr      (fault_clr),
        .mclk_src_sel   (mclk_src_sel),
        .aclk_src_sel   (aclk_src_sel),
        .fault_ie_wr    (fault_ie_wr),
        .fault_ie_wdata (fault_ie_wdata),
        .mclk_src_eff   (mclk_src_eff),
        .aclk_src_eff   (aclk_src_eff),
        .fault_flag     (fault_flag),
        .fault_ie       (fault_ie)
    );

    assign fault_irq = fault_flag & fault_ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_wait <= 1'b0;
        else        mem_wait <= (mclk_freq_mhz > WS_LIMIT);
    end

    assert_ws_above_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_freq_mhz > WS_LIMIT) |=> mem_wait);

    assert_ws_below_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_freq_mhz <= WS_LIMIT) |=> !mem_wait);
endmodule

// File: tb/sim_clkreq_fallback_ctrl.sv
module sim_clkreq_fallback_ctrl;
    localparam int NUM_REQ = 4;
    localparam int FREQ_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] lpm_code = '0;
    logic [NUM_REQ-1:0] rq [4];
    logic [3:0] req_en = '0;
    logic xt_fault_raw = 1'b0, xt_hf_mode = 1'b0;
    logic [1:0] mclk_src_sel = 2'd0, aclk_src_sel = 2'd2;
    logic [FREQ_W-1:0] mclk_freq_mhz = '0;
    logic fault_clr = 1'b0, fault_ie_wr = 1'b0, fault_ie_wdata = 1'b0;
    logic [3:0] gate_en;
    logic [1:0] mclk_src_eff, aclk_src_eff;
    logic fault_flag, fault_ie, fault_irq, mem_wait;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    clkreq_fallback_ctrl #(.NUM_REQ(NUM_REQ), .FREQ_W(FREQ_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lpm_code(lpm_code),
        .req_mclk(rq[0]), .req_smclk(rq[1]), .req_aclk(rq[2]), .req_modosc(rq[3]),
        .req_en(req_en), .xt_fault_raw(xt_fault_raw), .xt_hf_mode(xt_hf_mode),
        .mclk_src_sel(mclk_src_sel), .aclk_src_sel(aclk_src_sel),
        .mclk_freq_mhz(mclk_freq_mhz), .fault_clr(fault_clr),
        .fault_ie_wr(fault_ie_wr), .fault_ie_wdata(fault_ie_wdata),
        .gate_en(gate_en), .mclk_src_eff(mclk_src_eff), .aclk_src_eff(aclk_src_eff),
        .fault_flag(fault_flag), .fault_ie(fault_ie), .fault_irq(fault_irq),
        .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] mode_row(input int code);
        case (code)
            0: return 4'b1111;
            1: return 4'b1110;
            2: return 4'b0110;
            3: return 4'b0100;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic t_reset();
        for (int c = 0; c < 4; c++) rq[c] = '0;
        @(negedge clk);
        chk("R11 gates", gate_en, 4'b1111);
        chk("R11 flag", fault_flag, 0);
        chk("R11 ie", fault_ie, 0);
        chk("R11 irq", fault_irq, 0);
        chk("R11 mclk src", mclk_src_eff, 0);
        chk("R11 aclk src", aclk_src_eff, 2);
        chk("R11 wait", mem_wait, 0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_gate_matrix();
        for (int code = 0; code < 8; code++)
            for (int en = 0; en < 16; en++)
                for (int rp = 0; rp < 16; rp++) begin
                    logic [3:0] exp;
                    lpm_code = 3'(code);
                    req_en = 4'(en);
                    for (int c = 0; c < 4; c++)
                        rq[c] = rp[c] ? NUM_REQ'(1) << ((code + en + c) % NUM_REQ) : '0;
                    exp = mode_row(code) | (4'(en) & 4'(rp));
                    step(1);
                    if ((en & rp) != 0)  chk("R1 gates", gate_en, exp);
                    else if (en != 0)    chk("R2 gates", gate_en, exp);
                    else                 chk("R3 gates", gate_en, exp);
                    if (code == 3) chk("R4 smclk", gate_en[1], en[1] & rp[1]);
                end
        for (int c = 0; c < 4; c++) rq[c] = '0;
        req_en = '0;
        lpm_code = '0;
        step(1);
    endtask

    task automatic t_fault_lf();
        mclk_src_sel = 2'd1; aclk_src_sel = 2'd1; xt_hf_mode = 1'b0;
        fault_ie_wr = 1'b1; fault_ie_wdata = 1'b1;
        step(1);
        fault_ie_wr = 1'b0;
        chk("R5 pre mclk xt", mclk_src_eff, 1);
        xt_fault_raw = 1'b1;
        step(2);
        chk("R7 flag not yet", fault_flag, 0);
        step(1);
        chk("R7 flag set", fault_flag, 1);
        chk("R5 mclk refo", mclk_src_eff, 2);
        chk("R5 aclk refo", aclk_src_eff, 2);
        chk("R8 ie kept", fault_ie, 1);
        chk("R8 irq", fault_irq, 1);
        xt_hf_mode = 1'b1;
        step(2);
        chk("R7 mode latched", mclk_src_eff, 2);
        mclk_src_sel = 2'd3;
        step(1);
        chk("R10 vlo pass in fault", mclk_src_eff, 3);
        mclk_src_sel = 2'd1;
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        chk("R7 clear while faulty", fault_flag, 1);
        xt_fault_raw = 1'b0;
        step(3);
        chk("R7 sticky after fault gone", fault_flag, 1);
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        chk("R7 cleared", fault_flag, 0);
        chk("R7 mclk back to xt", mclk_src_eff, 1);
        chk("R8 irq off", fault_irq, 0);
        chk("R8 ie after clear", fault_ie, 1);
    endtask

    task automatic t_fault_hf();
        xt_hf_mode = 1'b1; mclk_src_sel = 2'd1; aclk_src_sel = 2'd1;
        xt_fault_raw = 1'b1;
        step(3);
        chk("R6 flag", fault_flag, 1);
        chk("R6 mclk dco", mclk_src_eff, 0);
        chk("R6 aclk refo", aclk_src_eff, 2);
        xt_hf_mode = 1'b0;
        step(1);
        chk("R7 hf latched", mclk_src_eff, 0);
        xt_fault_raw = 1'b0;
        step(3);
        fault_clr = 1'b1;
        step(1);
        fault_clr = 1'b0;
        chk("R7 hf cleared", fault_flag, 0);
        fault_ie_wr = 1'b1; fault_ie_wdata = 1'b0;
        step(1);
        fault_ie_wr = 1'b0;
        chk("R8 ie write 0", fault_ie, 0);
    endtask

    task automatic t_wait();
        mclk_freq_mhz = 5'd8;  step(1); chk("R9 8MHz", mem_wait, 0);
        mclk_freq_mhz = 5'd9;  step(1); chk("R9 9MHz", mem_wait, 1);
        mclk_freq_mhz = 5'd16; step(1); chk("R9 16MHz", mem_wait, 1);
        mclk_freq_mhz = 5'd1;  step(1); chk("R9 1MHz", mem_wait, 0);
    endtask

    task automatic t_aclk_sel();
        aclk_src_sel = 2'd0; step(1); chk("R10 dco req", aclk_src_eff, 2);
        aclk_src_sel = 2'd3; step(1); chk("R10 vlo", aclk_src_eff, 3);
        aclk_src_sel = 2'd1; step(1); chk("R10 xt", aclk_src_eff, 1);
        mclk_src_sel = 2'd3; step(1); chk("R10 mclk vlo", mclk_src_eff, 3);
    endtask

    initial begin
        t_reset();
        t_gate_matrix();
        t_fault_lf();
        t_fault_hf();
        t_wait();
        t_aclk_sel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule